// File: doc/BRIEF.md
# CAN Control/Status Register with Message Timestamp Timer

This block holds one byte-wide control and status register of a CAN controller, together with a 16-bit timer that timestamps messages. Software reads the register as a byte and writes it as a byte. The protocol engine feeds it the following event and status lines:

- frame received correctly
- receiver busy
- bus synchronized
- message acknowledged
- bit-clock tick
- initialization mode
- request to enter sleep

The register latches a sticky received-frame flag. Software clears that flag by writing a one to it. The register also shows the two live status bits from the protocol engine. It holds three control bits: stop clocks in wait, timer enable and wake-up enable.

When the timer is enabled, it counts bit-clock ticks. When it is disabled, it sits at zero. It cannot run during initialization. When a message is acknowledged, the block presents the current count as two bytes and raises a one-cycle strobe. The strobe writes those bytes into the two top bytes of the active message buffer. The wake-up enable is copied to a separate output only at sleep entry.

Top module: `can_ctlstat_reg`

## Requirements
- R1: The register byte reads as bit 7 received-frame flag, bit 6 receiver busy, bit 5 stop-in-wait, bit 4 synchronized, bit 3 timer enable, bit 2 wake-up enable. Bits 5 and 2 take the written data on every write, and the stop-in-wait bit also drives `stop_in_wait`.
- R2: A cycle with `rx_frame_ok` high sets the received-frame flag on the next edge. If a write with data bit 7 = 1 arrives in the same cycle, the flag still ends up set.
- R3: Once set, the received-frame flag stays set until reset or until a write with data bit 7 = 1. A write with data bit 7 = 0 leaves it unchanged.
- R4: Bits 6 and 4 of the read byte follow `rx_busy` and `bus_synced` in the same cycle, and writes do not affect them.
- R5: While the timer enable is 1, the timer advances by one on each clock edge that sees `bit_tick` high, and it wraps from 0xFFFF to 0x0000. Otherwise it holds its value.
- R6: While the timer enable reads 0, the timer is cleared to zero on the next edge.
- R7: While `init_mode` is high, the timer enable is forced to 0 on the next edge, and writes to bit 3 are ignored.
- R8: `ts_wr` is high exactly in the cycles where `msg_acked` is high and the timer enable reads 1. `ts_hi` (buffer byte 0xE) carries timer bits 15:8, and `ts_lo` (byte 0xF) carries bits 7:0.
- R9: `wake_latched` loads the register's wake-up enable bit only on an edge where `sleep_enter` is high. Changes to bit 2 at any other time do not reach it.
- R10: Bits 1 and 0 always read 0, whatever is written.
- R11: After reset, the register reads 0x00 apart from the live status bits, and the timer, `ts_wr`, `stop_in_wait` and `wake_latched` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register byte write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read byte |
| rx_frame_ok | input | 1 | Valid frame received (pulse) |
| rx_busy | input | 1 | Receiver active status |
| bus_synced | input | 1 | Bus synchronized status |
| msg_acked | input | 1 | Message acknowledged on bus (pulse) |
| bit_tick | input | 1 | Bit-clock tick |
| init_mode | input | 1 | Controller in initialization mode |
| sleep_enter | input | 1 | Sleep entry request |
| ts_hi | output | 8 | Timestamp byte for buffer offset 0xE |
| ts_lo | output | 8 | Timestamp byte for buffer offset 0xF |
| ts_wr | output | 1 | Timestamp write strobe |
| stop_in_wait | output | 1 | Stop clocks in wait mode |
| wake_latched | output | 1 | Wake-up enable captured at sleep entry |

## Verification
The bench drives a received frame in the same cycle as a write-one-to-clear. A design where the clear won would drop the frame. It also writes zeros to bit 7 to catch a flag that clears on any write.

The timer is run through a full wrap under a steady tick, then disabled and re-enabled. A design that kept the old count, or that stopped at 0xFFFF, would show a wrong timestamp on the next acknowledge.

Writes to bit 3 are attempted during initialization, and acknowledges are sent while the timer is off. This exposes an enable that leaks through, or a strobe issued with a zero timestamp. The wake-up bit is toggled while asleep to catch a latch that tracks the register instead of sampling it at sleep entry.

// File: rtl/can_ctlstat_reg.sv
module can_ctlstat_reg #(
  parameter int TS_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       rx_frame_ok,
  input  logic       rx_busy,
  input  logic       bus_synced,
  input  logic       msg_acked,
  input  logic       bit_tick,
  input  logic       init_mode,
  input  logic       sleep_enter,
  output logic [7:0] ts_hi,
  output logic [7:0] ts_lo,
  output logic       ts_wr,
  output logic       stop_in_wait,
  output logic       wake_latched
);
  localparam int HALF = TS_W / 2;

  logic            rxf_q, stopw_q, ten_q, wake_q;
  logic [TS_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxf_q        <= 1'b0;
      stopw_q      <= 1'b0;
      ten_q        <= 1'b0;
      wake_q       <= 1'b0;
      wake_latched <= 1'b0;
    end else begin
      if (rx_frame_ok)                rxf_q <= 1'b1;
      else if (wr_en && wr_data[7])   rxf_q <= 1'b0;
      if (wr_en) begin
        stopw_q <= wr_data[5];
        wake_q  <= wr_data[2];
      end
      if (init_mode)  ten_q <= 1'b0;
      else if (wr_en) ten_q <= wr_data[3];
      if (sleep_enter) wake_latched <= wake_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ten_q) tmr_q <= '0;
    else if (bit_tick)    tmr_q <= tmr_q + 1'b1;
  end

  assign rd_data      = {rxf_q, rx_busy, stopw_q, bus_synced, ten_q, wake_q, 2'b00};
  assign ts_hi        = tmr_q[TS_W-1:HALF];
  assign ts_lo        = tmr_q[HALF-1:0];
  assign ts_wr        = msg_acked & ten_q;
  assign stop_in_wait = stopw_q;
endmodule

// File: rtl/can_ctlstat_reg_chk.sv
module can_ctlstat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       rx_frame_ok,
  input logic       msg_acked,
  input logic       bit_tick,
  input logic       init_mode,
  input logic       sleep_enter,
  input logic [7:0] ts_hi,
  input logic [7:0] ts_lo,
  input logic       ts_wr,
  input logic       wake_latched
);
  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_ok |=> rd_data[7]); // R2
  AST_RXF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !(wr_en && wr_data[7])) |=> rd_data[7]); // R3
  AST_TMR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[3] && $past(!rd_data[3])) |-> ({ts_hi, ts_lo} == 16'h0)); // R6
  AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && $past(rd_data[3]) && !$past(bit_tick)) |-> $stable({ts_hi, ts_lo})); // R5
  AST_INIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> !rd_data[3]); // R7
  AST_STROBE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ts_wr |-> (rd_data[3] && msg_acked)); // R8
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_enter |=> $stable(wake_latched)); // R9
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00); // R10
endmodule

bind can_ctlstat_reg can_ctlstat_reg_chk u_chk (.*);

// File: tb/can_ctlstat_reg_bench.sv
module can_ctlstat_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rx_frame_ok = 0, rx_busy = 0, bus_synced = 0;
  logic msg_acked = 0, bit_tick = 0, init_mode = 0, sleep_enter = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, ts_hi, ts_lo;
  logic ts_wr, stop_in_wait, wake_latched;

  int n_run = 0, n_fail = 0;

  // reference model state
  bit m_rxf, m_sw, m_en, m_wu, m_wl;
  int m_tmr;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_ctlstat_reg u_can_ctlstat_reg (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxf = 0; m_sw = 0; m_en = 0; m_wu = 0; m_wl = 0; m_tmr = 0;
    end else begin
      if (!m_en) m_tmr = 0;
      else if (bit_tick) m_tmr = (m_tmr + 1) % 65536;
      if (sleep_enter) m_wl = m_wu;
      if (rx_frame_ok) m_rxf = 1;
      else if (wr_en && wr_data[7]) m_rxf = 0;
      if (init_mode) m_en = 0;
      else if (wr_en) m_en = wr_data[3];
      if (wr_en) begin m_sw = wr_data[5]; m_wu = wr_data[2]; end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3", "rx flag", int'(rd_data[7]), int'(m_rxf));
    chk("R4", "busy", int'(rd_data[6]), int'(rx_busy));
    chk("R4", "synced", int'(rd_data[4]), int'(bus_synced));
    chk("R1", "stop bit", int'({rd_data[5], stop_in_wait}), int'({m_sw, m_sw}));
    chk("R7", "timer enable", int'(rd_data[3]), int'(m_en));
    chk("R1", "wake bit", int'(rd_data[2]), int'(m_wu));
    chk("R10", "low bits", int'(rd_data[1:0]), 0);
    chk(m_en ? "R5" : "R6", "timer", int'({ts_hi, ts_lo}), m_tmr);
    chk("R8", "strobe", int'(ts_wr), int'(msg_acked && m_en));
    chk("R9", "wake latch", int'(wake_latched), int'(m_wl));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    // R11 reset state
    chk("R11", "reset rd", int'(rd_data), 0);
    chk("R11", "reset outs", int'({ts_hi, ts_lo, ts_wr, stop_in_wait, wake_latched}), 0);
    rst_n = 1; step();
    rx_busy = 1; bus_synced = 1; step();
    wr(8'hFF); wr(8'hFF);            // R10 low bits ignore writes
    rx_busy = 0; step();
    // R5 ticks
    for (int i = 0; i < 40; i++) begin bit_tick = i[0]; step(); end
    bit_tick = 0;
    msg_acked = 1; step(); msg_acked = 0; step();   // R8
    // R2 R3 received flag
    rx_frame_ok = 1; step(); rx_frame_ok = 0; step();
    wr(8'h2C); step();               // write 0 to bit 7: no clear
    wr(8'hAC); step();               // clear
    rx_frame_ok = 1; wr(8'hAC); rx_frame_ok = 0; step();  // set wins
    // R7 init forcing
    init_mode = 1; step();
    wr(8'h08); wr(8'h08);
    msg_acked = 1; step(); msg_acked = 0;
    init_mode = 0; step();
    // R6 disabled stays zero
    for (int i = 0; i < 10; i++) begin bit_tick = 1; step(); end
    wr(8'h0C);
    // R9 wake latch
    sleep_enter = 1; step(); sleep_enter = 0;
    wr(8'h08); step(); wr(8'h0C); step();
    sleep_enter = 1; wr(8'h08); sleep_enter = 0; step();
    sleep_enter = 1; step(); sleep_enter = 0; step();
    // R5 full wrap
    bit_tick = 1;
    for (int i = 0; i < 65545; i++) step();
    msg_acked = 1; step(); msg_acked = 0;
    bit_tick = 0;
    wr(8'h00); step(); wr(8'h08); step();
    msg_acked = 1; step(); msg_acked = 0; step();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule